// File: doc/BRIEF.md
# Two-Point Linear ADC Calibration Unit

This block corrects the gain and offset of a converter from two internal reference points. When asked to calibrate, it steers a small reference multiplexer to a quarter-of-supply level, waits a programmable settle time, and requests one conversion from an external sampler over a request/done handshake. It repeats the same steps at the three-quarter level. It then turns the two readings into a fixed-point scale (unity = 1,000,000) and an integer bias, and returns the multiplexer to the external input.

In normal operation every raw code offered on the input port is multiplied by the scale, divided by one million, offset by the bias and clamped to the converter's code range. The corrected code appears one clock later. If the two readings are not strictly increasing, the calibration is rejected and the previous coefficients stay in force. The division that forms the scale may be iterative (one quotient bit per clock) or single-cycle, chosen by a parameter.

Top module: `lin_cal_unit`

## Requirements
- R1: After reset the scale is 1,000,000 and the bias is 0, so every accepted raw code is returned unchanged; `ref_sel` reads 7, and `busy`, `conv_req`, `cal_done` and `corr_valid` are low.
- R2: The reference select uses code 1 for quarter supply, 3 for three-quarter supply and 7 for the external input (0 ground, 2 half, 4 full are not driven). A calibration drives exactly 1, then 3, then 7, and `ref_sel` is 7 whenever `cal_done` is high, on success and on failure alike.
- R3: After every change of `ref_sel`, at least `settle_cycles`+1 clock cycles pass before `conv_req` rises or `cal_done` is pulsed.
- R4: `conv_req` stays high until a cycle in which `conv_done` is high; `conv_code` is captured in that cycle.
- R5: With N-bit resolution, nominal targets n0 = 2^N/4 and n1 = 3·2^N/4, and readings v0 < v1, the new scale is (n1−n0)·1,000,000/(v1−v0) and the new bias is n0 − v0·scale/1,000,000. Divisions truncate toward zero and products are 64-bit signed.
- R6: An accepted raw code r yields, one cycle later on `corr_code` with `corr_valid` high, r·scale/1,000,000 + bias (truncated toward zero), clamped to 0..2^N−1.
- R7: If the second reading is not strictly greater than the first, `cal_done` pulses with `cal_fail` high and the scale and bias keep their previous values.
- R8: `busy` is high from the cycle after an accepted `cal_start` through the `cal_done` cycle; while `busy` is high, `raw_ready` is low and `raw_valid` produces no corrected output.
- R9: `cal_start` while `busy` is high is ignored: the running calibration ends with exactly one `cal_done` and the reference sequence is not restarted.
- R10: The resolution parameter is limited to 10 or 12 bits; the full-scale code 2^N−1 passes unchanged when uncalibrated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | Start a calibration (accepted only when idle) |
| settle_cycles | input | SETTLE_W | Wait count applied after each reference change |
| ref_sel | output | 3 | Reference multiplexer code |
| conv_req | output | 1 | Conversion request to the sampler |
| conv_done | input | 1 | Sampler has a result on conv_code |
| conv_code | input | RES_BITS | Sampler result |
| raw_valid | input | 1 | Raw code offered for correction |
| raw_code | input | RES_BITS | Raw code to correct |
| raw_ready | output | 1 | Correction input accepted this cycle when high |
| corr_valid | output | 1 | Corrected code valid |
| corr_code | output | RES_BITS | Corrected, clamped code |
| busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle pulse at the end of a calibration |
| cal_fail | output | 1 | High with cal_done when the readings were rejected |

## Verification
The bench builds the unit with 10-bit resolution, an 8-bit settle counter and the iterative divider. The 10-bit range makes both clamp limits easy to hit: it uses reading pairs whose coefficients push low codes below zero and high codes past 1023. The iterative divider takes 30 cycles per calibration, so raw codes and a second start can arrive while it runs. Settle counts of 0, 1, 2, 3 and 20 show the minimum wait as well as a long one. A behavioural model recomputes the coefficients from the readings it supplied and predicts the correction output on every clock.

// File: rtl/lcal_pkg.sv
`timescale 1ns/1ps
package lcal_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_CONV,
      ST_DIV,
      ST_BIAS,
      ST_DONE
   } cal_state_t;

   typedef enum logic [1:0] {
      PH_LOW,
      PH_HIGH,
      PH_RESTORE
   } cal_phase_t;

   localparam logic [2:0] MUX_QUARTER = 3'd1;
   localparam logic [2:0] MUX_THREEQ  = 3'd3;
   localparam logic [2:0] MUX_EXT     = 3'd7;

   localparam logic signed [63:0] FX_ONE = 64'sd1000000;

endpackage

// File: rtl/lcal_div.sv
`timescale 1ns/1ps
module lcal_div #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         done,
   output logic [W-1:0] quo
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  quo_q, rem_q, den_q, num_q;
   logic [CW-1:0] cnt;
   logic          run, done_q;
   logic [W:0]    shifted, diff;
   logic          ge;
   logic [W-1:0]  rem_n;

   always_comb begin
      shifted = {rem_q, quo_q[W-1]};
      diff    = shifted - {1'b0, den_q};
      ge      = ~diff[W];
      rem_n   = ge ? diff[W-1:0] : shifted[W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quo_q  <= '0;
         rem_q  <= '0;
         den_q  <= '0;
         num_q  <= '0;
         cnt    <= '0;
         run    <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            quo_q <= num;
            num_q <= num;
            den_q <= den;
            rem_q <= '0;
            cnt   <= CW'(W);
            run   <= 1'b1;
         end else if (run) begin
            quo_q <= {quo_q[W-2:0], ge};
            rem_q <= rem_n;
            cnt   <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               run    <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign done = done_q;
   assign quo  = quo_q;

   // R5: quotient and remainder reconstruct the latched numerator exactly
   p_div_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ((({{W{1'b0}}, quo_q} * {{W{1'b0}}, den_q}) + {{W{1'b0}}, rem_q})
                  == {{W{1'b0}}, num_q}) && (rem_q < den_q));

endmodule

// File: rtl/lcal_apply.sv
`timescale 1ns/1ps
module lcal_apply
   import lcal_pkg::*;
#(
   parameter int RES_BITS = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [RES_BITS-1:0] in_code,
   input  logic signed [63:0]  scale,
   input  logic signed [63:0]  bias,
   output logic                out_valid,
   output logic [RES_BITS-1:0] out_code
);
   localparam logic signed [63:0] CODE_MAX_S = (64'sd1 <<< RES_BITS) - 64'sd1;
   localparam logic [RES_BITS-1:0] CODE_MAX  = {RES_BITS{1'b1}};

   logic signed [63:0]  raw_s, prod, quot, sum;
   logic [RES_BITS-1:0] clamped;

   always_comb begin
      raw_s = $signed({{(64-RES_BITS){1'b0}}, in_code});
      prod  = raw_s * scale;
      quot  = prod / FX_ONE;
      sum   = quot + bias;
      if (sum < 64'sd0)
         clamped = '0;
      else if (sum > CODE_MAX_S)
         clamped = CODE_MAX;
      else
         clamped = sum[RES_BITS-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_code  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            out_code <= clamped;
      end
   end

   // R1: unity coefficients return the raw code unchanged
   p_identity_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && $past(in_valid) && ($past(scale) == FX_ONE) && ($past(bias) == 64'sd0)
      |-> out_code == $past(in_code));

endmodule

// File: rtl/lin_cal_unit.sv
`timescale 1ns/1ps
module lin_cal_unit
   import lcal_pkg::*;
#(
   parameter int RES_BITS = 12,
   parameter int SETTLE_W = 8,
   parameter bit ITER_DIV = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cal_start,
   input  logic [SETTLE_W-1:0] settle_cycles,
   output logic [2:0]          ref_sel,
   output logic                conv_req,
   input  logic                conv_done,
   input  logic [RES_BITS-1:0] conv_code,
   input  logic                raw_valid,
   input  logic [RES_BITS-1:0] raw_code,
   output logic                raw_ready,
   output logic                corr_valid,
   output logic [RES_BITS-1:0] corr_code,
   output logic                busy,
   output logic                cal_done,
   output logic                cal_fail
);
   localparam int NUM_W = RES_BITS + 20;
   localparam logic signed [63:0] NOM0_S   = 64'sd1 <<< (RES_BITS - 2);
   localparam logic signed [63:0] SPAN_S   = 64'sd1 <<< (RES_BITS - 1);
   localparam logic signed [63:0] NUM_S    = SPAN_S * FX_ONE;
   localparam logic [NUM_W-1:0]   CAL_NUM  = NUM_W'(NUM_S);

   initial begin
      a_res_r10: assert (RES_BITS == 10 || RES_BITS == 12)
         else $error("lin_cal_unit: RES_BITS must be 10 or 12");
      a_settle_w: assert (SETTLE_W >= 1 && SETTLE_W <= 24)
         else $error("lin_cal_unit: SETTLE_W out of range");
   end

   cal_state_t          state;
   cal_phase_t          phase;
   logic [SETTLE_W-1:0] cnt;
   logic [2:0]          ref_q;
   logic [RES_BITS-1:0] v0_q, v1_q;
   logic                fail_q, div_go, div_done;
   logic [NUM_W-1:0]    div_den, div_quo;
   logic signed [63:0]  scale_tmp, scale_q, bias_q, bias_new, v0_s;

   assign div_den = NUM_W'(v1_q) - NUM_W'(v0_q);

   generate
      if (ITER_DIV) begin : g_iter_div
         lcal_div #(.W(NUM_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .start (div_go),
            .num   (CAL_NUM),
            .den   (div_den),
            .done  (div_done),
            .quo   (div_quo)
         );
      end else begin : g_flat_div
         logic             done_f;
         logic [NUM_W-1:0] quo_f;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               done_f <= 1'b0;
               quo_f  <= '0;
            end else begin
               done_f <= div_go;
               if (div_go)
                  quo_f <= CAL_NUM / div_den;
            end
         end
         assign div_done = done_f;
         assign div_quo  = quo_f;
      end
   endgenerate

   always_comb begin
      v0_s     = $signed({{(64-RES_BITS){1'b0}}, v0_q});
      bias_new = NOM0_S - ((v0_s * scale_tmp) / FX_ONE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         phase     <= PH_LOW;
         cnt       <= '0;
         ref_q     <= MUX_EXT;
         v0_q      <= '0;
         v1_q      <= '0;
         fail_q    <= 1'b0;
         div_go    <= 1'b0;
         scale_tmp <= '0;
         scale_q   <= FX_ONE;
         bias_q    <= '0;
      end else begin
         div_go <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (cal_start) begin
                  ref_q  <= MUX_QUARTER;
                  cnt    <= settle_cycles;
                  phase  <= PH_LOW;
                  fail_q <= 1'b0;
                  state  <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (cnt == '0)
                  state <= (phase == PH_RESTORE) ? ST_DONE : ST_CONV;
               else
                  cnt <= cnt - 1'b1;
            end
            ST_CONV: begin
               if (conv_done) begin
                  if (phase == PH_LOW) begin
                     v0_q  <= conv_code;
                     ref_q <= MUX_THREEQ;
                     cnt   <= settle_cycles;
                     phase <= PH_HIGH;
                     state <= ST_SETTLE;
                  end else begin
                     v1_q <= conv_code;
                     if (conv_code > v0_q) begin
                        div_go <= 1'b1;
                        state  <= ST_DIV;
                     end else begin
                        fail_q <= 1'b1;
                        ref_q  <= MUX_EXT;
                        cnt    <= settle_cycles;
                        phase  <= PH_RESTORE;
                        state  <= ST_SETTLE;
                     end
                  end
               end
            end
            ST_DIV: begin
               if (div_done) begin
                  scale_tmp <= $signed({{(64-NUM_W){1'b0}}, div_quo});
                  state     <= ST_BIAS;
               end
            end
            ST_BIAS: begin
               scale_q <= scale_tmp;
               bias_q  <= bias_new;
               ref_q   <= MUX_EXT;
               cnt     <= settle_cycles;
               phase   <= PH_RESTORE;
               state   <= ST_SETTLE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign ref_sel   = ref_q;
   assign conv_req  = (state == ST_CONV);
   assign busy      = (state != ST_IDLE);
   assign cal_done  = (state == ST_DONE);
   assign cal_fail  = fail_q & (state == ST_DONE);
   assign raw_ready = ~busy;

   lcal_apply #(.RES_BITS(RES_BITS)) u_apply (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (raw_valid & ~busy),
      .in_code   (raw_code),
      .scale     (scale_q),
      .bias      (bias_q),
      .out_valid (corr_valid),
      .out_code  (corr_code)
   );

   // R4: request held until the sampler answers
   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req && !conv_done |=> conv_req);

   // R2: multiplexer back on the external input at the end of every calibration
   p_restore_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |-> ref_sel == MUX_EXT);

   // R2: only the three driven codes ever appear
   p_mux_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_sel == MUX_QUARTER) || (ref_sel == MUX_THREEQ) || (ref_sel == MUX_EXT));

   // R8: no corrected output follows a busy cycle
   p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !corr_valid);

   // R8: an accepted start raises busy
   p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start && !busy |=> busy);

   // R7: a rejected pair leaves the coefficients untouched
   p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fail_q |-> $stable(scale_q) && $stable(bias_q));

endmodule

// File: tb/sim_lin_cal_unit.sv
`timescale 1ns/1ps
module sim_lin_cal_unit;
   localparam int RB  = 10;
   localparam int SW  = 8;
   localparam longint NOM0 = 256;
   localparam longint NOM1 = 768;
   localparam longint CMAX = 1023;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cal_start = 1'b0;
   logic [SW-1:0] settle_cycles = '0;
   logic [2:0]    ref_sel;
   logic          conv_req;
   logic          conv_done = 1'b0;
   logic [RB-1:0] conv_code = '0;
   logic          raw_valid = 1'b0;
   logic [RB-1:0] raw_code = '0;
   logic          raw_ready, corr_valid, busy, cal_done, cal_fail;
   logic [RB-1:0] corr_code;

   always #2.5 clk = ~clk;

   lin_cal_unit #(.RES_BITS(RB), .SETTLE_W(SW), .ITER_DIV(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .settle_cycles(settle_cycles),
      .ref_sel(ref_sel), .conv_req(conv_req), .conv_done(conv_done), .conv_code(conv_code),
      .raw_valid(raw_valid), .raw_code(raw_code), .raw_ready(raw_ready),
      .corr_valid(corr_valid), .corr_code(corr_code), .busy(busy),
      .cal_done(cal_done), .cal_fail(cal_fail));

   int     n_chk = 0, n_fail = 0, n_done = 0;
   string  cur_req = "R1";
   longint m_scale = 1000000, m_bias = 0;
   int     samp_v0 = 0, samp_v1 = 0, samp_dly = 2;
   bit     logging = 1'b0;
   int     ref_log[$];
   int     since = 0;
   logic [2:0] prev_ref = 3'd7;
   logic   prev_req = 1'b0;
   bit     pend_v = 1'b0;
   longint pend_c = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic longint m_corr(input longint raw);
      longint t;
      t = (raw * m_scale) / 1000000 + m_bias;
      if (t < 0) t = 0;
      if (t > CMAX) t = CMAX;
      return t;
   endfunction

   // cycle-by-cycle model of the correction path and reference sequencing
   always @(negedge clk) begin
      if (rst_n) begin
         if (pend_v || corr_valid) begin
            if (!pend_v)
               chk(1'b0, cur_req, longint'(corr_valid), 0);
            else
               chk(corr_valid === 1'b1 && longint'(corr_code) == pend_c, cur_req,
                   corr_valid ? longint'(corr_code) : -1, pend_c);
         end
         if (busy) chk(raw_ready == 1'b0, "R8", longint'(raw_ready), 0);
         pend_v = raw_valid && raw_ready;
         if (pend_v) pend_c = m_corr(longint'(raw_code));
         if (cal_done) n_done++;
         if (logging) begin
            if (ref_sel != prev_ref) begin
               ref_log.push_back(int'(ref_sel));
               since = 0;
            end else begin
               since++;
            end
            if (conv_req && !prev_req)
               chk(since >= int'(settle_cycles) + 1, "R3", since, int'(settle_cycles) + 1);
            if (cal_done)
               chk(since >= int'(settle_cycles) + 1, "R3", since, int'(settle_cycles) + 1);
         end
         prev_ref = ref_sel;
         prev_req = conv_req;
      end
   end

   // external sampler: answers each request after samp_dly cycles
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && conv_req) begin
            bit held;
            held = 1'b1;
            for (int i = 0; i < samp_dly; i++) begin
               @(posedge clk);
               #1;
               if (!conv_req) held = 1'b0;
            end
            chk(held, "R4", longint'(held), 1);
            if (ref_sel == 3'd1)      conv_code = RB'(samp_v0);
            else if (ref_sel == 3'd3) conv_code = RB'(samp_v1);
            else                      conv_code = '0;
            conv_done = 1'b1;
            @(posedge clk);
            #1 conv_done = 1'b0;
         end
      end
   end

   task automatic send_raws(input int codes[$]);
      foreach (codes[i]) begin
         @(posedge clk);
         #1 raw_valid = 1'b1;
         raw_code = RB'(codes[i]);
      end
      @(posedge clk);
      #1 raw_valid = 1'b0;
      repeat (2) @(posedge clk);
   endtask

   task automatic run_cal(input int a, input int b, input int s, input bit exp_fail);
      longint sc;
      samp_v0 = a;
      samp_v1 = b;
      settle_cycles = SW'(s);
      ref_log.delete();
      logging = 1'b1;
      @(posedge clk);
      #1 cal_start = 1'b1;
      @(posedge clk);
      #1 cal_start = 1'b0;
      @(negedge clk);
      chk(busy == 1'b1, "R8", longint'(busy), 1);
      while (!cal_done) @(negedge clk);
      chk(cal_fail == exp_fail, exp_fail ? "R7" : "R5", longint'(cal_fail), longint'(exp_fail));
      chk(ref_sel == 3'd7, "R2", longint'(ref_sel), 7);
      chk(ref_log.size() == 3 && ref_log[0] == 1 && ref_log[1] == 3 && ref_log[2] == 7,
          "R2", ref_log.size(), 3);
      if (!exp_fail) begin
         sc = ((NOM1 - NOM0) * 1000000) / longint'(b - a);
         m_scale = sc;
         m_bias = NOM0 - (longint'(a) * sc) / 1000000;
      end
      logging = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0, "R8", longint'(busy), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int dones_before;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(ref_sel == 3'd7, "R1", longint'(ref_sel), 7);
      chk(busy == 1'b0 && conv_req == 1'b0 && cal_done == 1'b0, "R1",
          longint'({busy, conv_req, cal_done}), 0);
      chk(corr_valid == 1'b0 && raw_ready == 1'b1, "R1", longint'({corr_valid, raw_ready}), 1);

      cur_req = "R1";
      send_raws('{0, 5, 512, 77});
      cur_req = "R10";
      send_raws('{1023});

      run_cal(250, 780, 3, 1'b0);
      cur_req = "R5";
      send_raws('{250, 780, 0});
      cur_req = "R6";
      send_raws('{1, 100, 999, 1023});

      samp_dly = 1;
      run_cal(300, 700, 0, 1'b0);
      cur_req = "R6";
      send_raws('{0, 100, 500, 1023, 900, 820});

      samp_dly = 3;
      run_cal(400, 400, 2, 1'b1);
      cur_req = "R7";
      send_raws('{0, 500, 1023});
      run_cal(600, 200, 1, 1'b1);
      cur_req = "R7";
      send_raws('{300, 800});

      dones_before = n_done;
      fork
         run_cal(260, 770, 20, 1'b0);
         begin
            repeat (6) @(posedge clk);
            #1 cal_start = 1'b1;
            raw_valid = 1'b1;
            raw_code = RB'(77);
            @(posedge clk);
            #1 cal_start = 1'b0;
            repeat (3) @(posedge clk);
            #1 raw_valid = 1'b0;
            repeat (40) @(posedge clk);
            #1 cal_start = 1'b1;
            @(posedge clk);
            #1 cal_start = 1'b0;
         end
      join
      repeat (40) @(posedge clk);
      @(negedge clk);
      chk(n_done - dones_before == 1, "R9", n_done - dones_before, 1);
      chk(busy == 1'b0, "R9", longint'(busy), 0);
      cur_req = "R6";
      send_raws('{10, 520, 260});

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule